// File: doc/BRIEF.md
# Inverted-AND execute slice

This block is one execution slice of a processor datapath. It computes the bitwise AND of the complement of one source operand with a second source operand. It picks the operand width from the processor mode and a decoded width-select bit, and it produces an updated flags vector. It also checks the decoded encoding and raises an invalid-opcode strobe when the operation is not allowed.

Operands, the mode, the decoded prefix bits and the incoming flags are taken in on a cycle where `in_valid` is high. Exactly one cycle later the slice presents the destination value, the new flags, a destination write-enable and the exception strobe. Register-file access, operand fetch and exception delivery belong to the surrounding pipeline.

Top module: `notand_exec`

## Requirements
- R1: One cycle after an accepted operation with no exception, `dest` equals the complement of `src_inv` ANDed with `src_pass`, taken at the active width.
- R2: When `cpu_mode` is 2 (32-bit protected or compatibility), the width is 32 bits whatever `wide_sel` holds, and `dest[63:32]` is zero.
- R3: When `cpu_mode` is 3 (64-bit), `wide_sel`=1 selects a 64-bit operation. `wide_sel`=0 selects a 32-bit operation whose upper 32 bits of `dest` are zero.
- R4: `len_bit`=1 sets `ud_trap` for that operation. In that case `dest_we` is 0, `dest` is 0 and `flags_out` equals `flags_in`.
- R5: `cpu_mode` 0 (real) or 1 (virtual-8086) sets `ud_trap`, with the same suppressed outputs as R4.
- R6: The sign flag, `flags_out[4]`, is bit 31 of the result for a 32-bit operation and bit 63 for a 64-bit operation.
- R7: The zero flag, `flags_out[3]`, is 1 exactly when the result at the active width is all zeros.
- R8: The overflow flag `flags_out[5]` and the carry flag `flags_out[0]` are 0 after any non-trapping operation. The aux-carry flag `flags_out[2]` and the parity flag `flags_out[1]` are copied from `flags_in`.
- R9: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high. `dest_we` equals `out_valid` and not `ud_trap`. In a cycle without a new result, `dest` and `flags_out` hold their previous values.
- R10: A synchronous active-high `rst` clears `out_valid`, `dest_we` and `ud_trap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe; inputs are sampled when high |
| src_inv | input | DATA_W | Source operand that is complemented |
| src_pass | input | DATA_W | Source operand used as is |
| cpu_mode | input | 2 | 0 real, 1 virtual-8086, 2 32-bit, 3 64-bit |
| wide_sel | input | 1 | Decoded width-select prefix bit |
| len_bit | input | 1 | Decoded vector-length prefix bit |
| flags_in | input | 6 | Current flags {OF,SF,ZF,AF,PF,CF} |
| out_valid | output | 1 | Result cycle marker |
| dest | output | DATA_W | Destination value |
| flags_out | output | 6 | Updated flags, same layout as flags_in |
| dest_we | output | 1 | Destination and flags write-enable |
| ud_trap | output | 1 | Invalid-opcode exception strobe |

## Verification
The bench builds the slice with its default `DATA_W` of 64. With that value the half-width boundary sits at bit 32, so one build reaches both the bit-31 and the bit-63 sign cases and shows the upper half being zeroed. Random operands across all four modes, both prefix bits and all-ones incoming flags are mixed with directed cases. These include results that are zero only in the low half and a sign bit that is set only in the upper half.

// File: rtl/notand_pkg.sv
package notand_pkg;

    localparam int FLAG_W   = 6;
    localparam int FLAG_CF  = 0;
    localparam int FLAG_PF  = 1;
    localparam int FLAG_AF  = 2;
    localparam int FLAG_ZF  = 3;
    localparam int FLAG_SF  = 4;
    localparam int FLAG_OF  = 5;

    typedef enum logic [1:0] {
        MODE_REAL   = 2'd0,
        MODE_V86    = 2'd1,
        MODE_PROT32 = 2'd2,
        MODE_LONG   = 2'd3
    } cpu_mode_e;

endpackage

// File: rtl/notand_mode_decode.sv
module notand_mode_decode
    import notand_pkg::*;
(
    input  logic [1:0] cpu_mode,
    input  logic       wide_sel,
    input  logic       len_bit,
    output logic       illegal,
    output logic       use_wide
);

    cpu_mode_e mode;

    always_comb begin
        mode     = cpu_mode_e'(cpu_mode);
        // Operation forbidden in the two legacy modes and with a nonzero length bit
        illegal  = len_bit || (mode == MODE_REAL) || (mode == MODE_V86);
        // Width prefix only honoured in 64-bit mode
        use_wide = (mode == MODE_LONG) && wide_sel;
    end

endmodule

// File: rtl/notand_datapath.sv
module notand_datapath
    import notand_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] src_inv,
    input  logic [DATA_W-1:0] src_pass,
    input  logic              use_wide,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] flags_new
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] full;
    logic              sign;

    always_comb begin
        full = ~src_inv & src_pass;
        if (use_wide) begin
            result = full;
            sign   = full[DATA_W-1];
        end else begin
            result = {{(DATA_W-HALF_W){1'b0}}, full[HALF_W-1:0]};
            sign   = full[HALF_W-1];
        end
        flags_new          = flags_in;
        flags_new[FLAG_SF] = sign;
        flags_new[FLAG_ZF] = (result == '0);
        flags_new[FLAG_OF] = 1'b0;
        flags_new[FLAG_CF] = 1'b0;
    end

endmodule

// File: rtl/notand_exec.sv
module notand_exec
    import notand_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_inv,
    input  logic [DATA_W-1:0] src_pass,
    input  logic [1:0]        cpu_mode,
    input  logic              wide_sel,
    input  logic              len_bit,
    input  logic [FLAG_W-1:0] flags_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] dest,
    output logic [FLAG_W-1:0] flags_out,
    output logic              dest_we,
    output logic              ud_trap
);

    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic              vld;
        logic              we;
        logic              trap;
        logic [DATA_W-1:0] dest;
        logic [FLAG_W-1:0] flags;
    } state_t;

    state_t            st_d, st_q;
    logic              illegal;
    logic              use_wide;
    logic [DATA_W-1:0] result;
    logic [FLAG_W-1:0] flags_new;

    notand_mode_decode u_decode (
        .cpu_mode (cpu_mode),
        .wide_sel (wide_sel),
        .len_bit  (len_bit),
        .illegal  (illegal),
        .use_wide (use_wide)
    );

    notand_datapath #(.DATA_W(DATA_W)) u_dp (
        .src_inv   (src_inv),
        .src_pass  (src_pass),
        .use_wide  (use_wide),
        .flags_in  (flags_in),
        .result    (result),
        .flags_new (flags_new)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = in_valid;
        st_d.we   = in_valid && !illegal;
        st_d.trap = in_valid && illegal;
        if (in_valid) begin
            st_d.dest  = illegal ? '0 : result;
            st_d.flags = illegal ? flags_in : flags_new;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.vld  <= 1'b0;
            st_q.we   <= 1'b0;
            st_q.trap <= 1'b0;
        end else begin
            st_q.vld  <= st_d.vld;
            st_q.we   <= st_d.we;
            st_q.trap <= st_d.trap;
        end
        st_q.dest  <= st_d.dest;
        st_q.flags <= st_d.flags;
    end

    assign out_valid = st_q.vld;
    assign dest_we   = st_q.we;
    assign ud_trap   = st_q.trap;
    assign dest      = st_q.dest;
    assign flags_out = st_q.flags;

    // Write-enable and trap never together
    p_we_excl_trap_r4: assert property (@(posedge clk) disable iff (rst)
        !(dest_we && ud_trap));

    p_len_trap_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && len_bit) |=> (ud_trap && !dest_we && dest == '0));

    p_legacy_trap_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cpu_mode[1] == 1'b0) |=> ud_trap);

    p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !ud_trap && !dest_we));

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cpu_mode == 2'd2) |=> (dest[DATA_W-1:HALF_W] == '0));

    p_zero_flag_r7: assert property (@(posedge clk) disable iff (rst)
        dest_we |-> (flags_out[FLAG_ZF] == (dest == '0)));

    p_clear_ovf_carry_r8: assert property (@(posedge clk) disable iff (rst)
        dest_we |-> (!flags_out[FLAG_OF] && !flags_out[FLAG_CF]));

endmodule

// File: tb/tb_notand_exec.sv
module tb_notand_exec;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] src_inv, src_pass;
    logic [1:0]  cpu_mode;
    logic        wide_sel, len_bit;
    logic [5:0]  flags_in;
    logic        out_valid;
    logic [63:0] dest;
    logic [5:0]  flags_out;
    logic        dest_we, ud_trap;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [63:0] exp_dest;
    logic [5:0]  exp_flags;

    always #4 clk = ~clk;

    notand_exec #(.DATA_W(64)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .src_inv(src_inv), .src_pass(src_pass),
        .cpu_mode(cpu_mode), .wide_sel(wide_sel), .len_bit(len_bit),
        .flags_in(flags_in), .out_valid(out_valid), .dest(dest),
        .flags_out(flags_out), .dest_we(dest_we), .ud_trap(ud_trap)
    );

    function automatic logic ref_trap(logic [1:0] m, logic l);
        return l || (m == 2'd0) || (m == 2'd1);
    endfunction

    function automatic logic [63:0] ref_dest(logic [63:0] a, logic [63:0] b,
                                             logic [1:0] m, logic w);
        logic [63:0] r;
        r = ~a & b;
        if (!(m == 2'd3 && w)) r[63:32] = 32'h0;
        return r;
    endfunction

    function automatic logic [5:0] ref_flags(logic [63:0] r, logic [1:0] m,
                                             logic w, logic [5:0] fin);
        logic [5:0] f;
        f    = fin;
        f[0] = 1'b0;
        f[5] = 1'b0;
        f[3] = (r == 64'h0);
        f[4] = (m == 2'd3 && w) ? r[63] : r[31];
        return f;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic run_op(logic [63:0] a, logic [63:0] b, logic [1:0] m,
                          logic w, logic l, logic [5:0] fin);
        logic t;
        @(negedge clk);
        src_inv = a; src_pass = b; cpu_mode = m;
        wide_sel = w; len_bit = l; flags_in = fin; in_valid = 1'b1;
        t = ref_trap(m, l);
        if (t) begin
            exp_dest  = 64'h0;
            exp_flags = fin;
        end else begin
            exp_dest  = ref_dest(a, b, m, w);
            exp_flags = ref_flags(exp_dest, m, w, fin);
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 out_valid", {63'h0, out_valid}, 64'h1);
        chk(l ? "R4 ud_trap" : "R5 ud_trap", {63'h0, ud_trap}, {63'h0, t});
        chk("R9 dest_we", {63'h0, dest_we}, {63'h0, !t});
        if (t) begin
            chk("R4 R5 dest suppressed", dest, exp_dest);
            chk("R4 R5 flags unchanged", {58'h0, flags_out}, {58'h0, exp_flags});
        end else begin
            chk(m == 2'd3 ? "R1 R3 dest" : "R1 R2 dest", dest, exp_dest);
            chk("R6 sign", {63'h0, flags_out[4]}, {63'h0, exp_flags[4]});
            chk("R7 zero", {63'h0, flags_out[3]}, {63'h0, exp_flags[3]});
            chk("R8 other flags", {60'h0, flags_out[5], flags_out[2:0]},
                {60'h0, exp_flags[5], exp_flags[2:0]});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; in_valid = 1'b1; src_inv = '0; src_pass = '0;
        cpu_mode = 2'd3; wide_sel = 1'b0; len_bit = 1'b0; flags_in = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 out_valid", {63'h0, out_valid}, 64'h0);
        chk("R10 dest_we", {63'h0, dest_we}, 64'h0);
        chk("R10 ud_trap", {63'h0, ud_trap}, 64'h0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        // R2: width bit ignored in 32-bit mode, sign from bit 31
        run_op(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 1'b1, 1'b0, 6'h3F);
        // R3 R6: 64-bit sign only in the upper half
        run_op(64'h0, 64'h8000_0000_0000_0000, 2'd3, 1'b1, 1'b0, 6'h3F);
        // R3 R7: same operands at 32 bits give zero
        run_op(64'h0, 64'h8000_0000_0000_0000, 2'd3, 1'b0, 1'b0, 6'h3F);
        // R7: full cancellation
        run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b1, 1'b0, 6'h21);
        // R4: length bit trap
        run_op(64'h0, 64'h1234, 2'd3, 1'b1, 1'b1, 6'h15);
        // R5: legacy modes trap
        run_op(64'h0, 64'h1234, 2'd0, 1'b0, 1'b0, 6'h2A);
        run_op(64'h0, 64'h1234, 2'd1, 1'b1, 1'b0, 6'h0C);

        // R9: idle cycle keeps data, no strobes
        run_op(64'h00F0, 64'h0FFF, 2'd2, 1'b0, 1'b0, 6'h00);
        @(negedge clk);
        chk("R9 idle out_valid", {63'h0, out_valid}, 64'h0);
        chk("R9 idle dest_we", {63'h0, dest_we}, 64'h0);
        chk("R9 idle ud_trap", {63'h0, ud_trap}, 64'h0);
        chk("R9 idle dest hold", dest, exp_dest);
        chk("R9 idle flags hold", {58'h0, flags_out}, {58'h0, exp_flags});

        for (int i = 0; i < 400; i++) begin
            logic [63:0] a, b;
            logic [1:0]  m;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if ($urandom % 4 == 0) b = a | 64'(1 << ($urandom % 64));
            m = 2'($urandom % 4);
            if ($urandom % 3 != 0) m = 2'd3;
            run_op(a, b, m, 1'($urandom), ($urandom % 8) == 0, 6'($urandom));
        end
        finish_run();
    end

endmodule